// File: doc/BRIEF.md
# Flash Write Status Bit Generator

This block produces the status word that a parallel NOR flash returns when the host reads it while an internal program or erase runs. The host starts an operation with a one-cycle strobe and gives it a type, a busy duration in clock cycles and, for a program, the word being written. Each later read strobe returns a status word. In it, bit 7 is a completion poll, bits 6 and 2 are toggle bits that alternate from one read to the next, and the remaining bits are a fixed marker. A separate ready output is low while the array is busy.

An erase can be suspended with a level input. While it is suspended, its remaining time is frozen, the device reports ready, and a single program may run to a sector that is not suspended. A status read learns which kind of sector it targets from the in-suspended-sector flag. After a program or erase finishes, bit 7 shows its final value at once. For a programmable settling window, the other data bits still return the marker, and only after that window does the array data come back.

Top module: `flash_stat_gen`

## Requirements
- R1: `ready_o` is 0 from the cycle after an accepted start until the operation finishes. It is also 0 while a program runs inside an erase suspend. It is 1 when idle and while an erase is suspended with no program running.
- R2: During a program, bit 7 of each status read is the inverse of bit 7 of the programmed word. In the first read after completion, bit 7 equals the true bit 7.
- R3: During an erase, bit 7 of each status read is 0. In the first read after completion, bit 7 is 1.
- R4: Bit 6 is cleared by every accepted start, so the first busy read returns 0. Every busy read then inverts it, so successive busy reads return 0,1,0,1.
- R5: Bit 2 is cleared by every accepted start. It inverts on every read during an erase and on every read of the suspended sector while the erase is suspended. It does not change during a program, so a program reads 0 on bit 2.
- R6: While an erase is suspended, a read with `in_susp_sector_i`=1 returns 1 on bit 7 and 1 on bit 6, together with the current bit-2 toggle value.
- R7: While an erase is suspended, a read with `in_susp_sector_i`=0 returns `array_data_i` unchanged and does not advance either toggle bit.
- R8: A program started while an erase is suspended reads the inverted bit 7 and a toggling bit 6. When it finishes, the block returns to the suspended state. The erase's remaining time does not decrease while the erase is suspended, and it resumes when `suspend_i` drops.
- R9: For `SETTLE_CYC` cycles after a program or erase finishes, an idle read returns bit 7 as in R2 or R3, bit 6 as its last toggle value, and all other bits from `INVALID_PAT`. After that window, an idle read returns `array_data_i`.
- R10: The status word for a read strobe sampled at one clock edge appears on `rd_data_o` after that edge. `rd_valid_o` is 1 for exactly that cycle.
- R11: A start is ignored while a program or erase is busy. An erase start is also ignored while an erase is suspended.
- R12: After reset, `ready_o`=1 and `rd_valid_o`=0, and a read returns `array_data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle operation start |
| op_i | input | 1 | Operation type: 0 program, 1 erase |
| len_i | input | LEN_W | Busy duration in cycles (0 counts as 1) |
| prog_data_i | input | DATA_W | Word being programmed |
| suspend_i | input | 1 | Erase suspend request (level) |
| in_susp_sector_i | input | 1 | Read address lies in the suspended sector |
| array_data_i | input | DATA_W | Normal array read data |
| rd_i | input | 1 | Status read strobe |
| rd_data_o | output | DATA_W | Returned read word |
| rd_valid_o | output | 1 | Read word valid |
| ready_o | output | 1 | 1 ready, 0 busy |

## Verification
The polling bits are exercised with three kinds of programmed word: bit 7 set with other bits clear, bit 7 clear with other bits set, and all ones. A plain erase is run alongside them. Together these separate a true complement of bit 7 from an inversion of the whole word or from a constant, and they separate the program toggle behaviour from the erase toggle behaviour. A suspended erase is then read both inside and outside the suspended sector, which separates sector-aware reporting from plain toggling. A program nested in the suspend that lasts longer than the erase's remaining time shows that the erase time stays frozen. Reads issued just after completion and again after the settling window separate marker output from array output.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_ERASE,
    ST_SUSP,
    ST_SPROG
  } fst_state_e;

  localparam int unsigned POLL_BIT = 7;
  localparam int unsigned TOGA_BIT = 6;
  localparam int unsigned TOGB_BIT = 2;
endpackage

// File: rtl/fst_timer.sv
module fst_timer #(
  parameter int unsigned W           = 16,
  parameter bit          ZERO_IS_ONE = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  input  logic         run_i,
  output logic         done_o,
  output logic         active_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] len_eff;

  always_comb begin
    len_eff = len_i;
    if (ZERO_IS_ONE && len_i == '0) len_eff = W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (load_i)               cnt_q <= len_eff;
    else if (run_i && cnt_q != '0) cnt_q <= cnt_q - W'(1);
  end

  assign done_o   = run_i && (cnt_q == W'(1));
  assign active_o = (cnt_q != '0);

  // R8: remaining time frozen when not running
  a_r8_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !load_i && !run_i) |=> $stable(cnt_q));
endmodule

// File: rtl/fst_toggle.sv
module fst_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (clr_i) q_o <= 1'b0;
    else if (en_i)  q_o <= ~q_o;
  end

  // R4 / R5: each enabled read flips, each start clears
  a_r4_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i) |=> (q_o != $past(q_o)));
  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !q_o);
endmodule

// File: rtl/fst_ctrl.sv
module fst_ctrl
  import flash_stat_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       op_i,
  input  logic       suspend_i,
  input  logic       data_b7_i,
  input  logic       prog_done_i,
  input  logic       erase_done_i,
  output fst_state_e state_o,
  output logic       acc_prog_o,
  output logic       acc_erase_o,
  output logic       finish_o,
  output logic       pdata_b7_o,
  output logic       last_b7_o
);
  fst_state_e st_q, st_d;

  assign acc_prog_o  = start_i && !op_i && (st_q == ST_IDLE || st_q == ST_SUSP);
  assign acc_erase_o = start_i &&  op_i && (st_q == ST_IDLE);
  assign finish_o    = (st_q == ST_PROG  && prog_done_i) ||
                       (st_q == ST_ERASE && erase_done_i);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (acc_prog_o)       st_d = ST_PROG;
        else if (acc_erase_o) st_d = ST_ERASE;
      end
      ST_PROG:  if (prog_done_i) st_d = ST_IDLE;
      ST_ERASE: begin
        if (erase_done_i)   st_d = ST_IDLE;
        else if (suspend_i) st_d = ST_SUSP;
      end
      ST_SUSP: begin
        if (acc_prog_o)      st_d = ST_SPROG;
        else if (!suspend_i) st_d = ST_ERASE;
      end
      ST_SPROG: if (prog_done_i) st_d = ST_SUSP;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      pdata_b7_o <= 1'b0;
      last_b7_o  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (acc_prog_o) pdata_b7_o <= data_b7_i;
      if (finish_o)   last_b7_o  <= (st_q == ST_ERASE) ? 1'b1 : pdata_b7_o;
    end
  end

  assign state_o = st_q;

  // R11: busy program is not displaced by any start
  a_r11_prog_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PROG && !prog_done_i) |=> st_q == ST_PROG);
  a_r11_sprog_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SPROG && !prog_done_i) |=> st_q == ST_SPROG);
  // R8: nested program returns to suspend
  a_r8_back_to_susp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SPROG && prog_done_i) |=> st_q == ST_SUSP);
endmodule

// File: rtl/fst_readout.sv
module fst_readout
  import flash_stat_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter logic [DATA_W-1:0] INVALID_PAT = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  fst_state_e        state_i,
  input  logic              rd_i,
  input  logic              in_susp_i,
  input  logic [DATA_W-1:0] array_data_i,
  input  logic              pdata_b7_i,
  input  logic              last_b7_i,
  input  logic              settle_i,
  input  logic              tog_a_i,
  input  logic              tog_b_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  logic [DATA_W-1:0] word;

  always_comb begin
    word = INVALID_PAT;
    unique case (state_i)
      ST_IDLE: begin
        if (settle_i) begin
          word[POLL_BIT] = last_b7_i;
          word[TOGA_BIT] = tog_a_i;
        end else begin
          word = array_data_i;
        end
      end
      ST_PROG, ST_SPROG: begin
        word[POLL_BIT] = ~pdata_b7_i;
        word[TOGA_BIT] = tog_a_i;
        word[TOGB_BIT] = tog_b_i;
      end
      ST_ERASE: begin
        word[POLL_BIT] = 1'b0;
        word[TOGA_BIT] = tog_a_i;
        word[TOGB_BIT] = tog_b_i;
      end
      ST_SUSP: begin
        if (in_susp_i) begin
          word[POLL_BIT] = 1'b1;
          word[TOGA_BIT] = 1'b1;
          word[TOGB_BIT] = tog_b_i;
        end else begin
          word = array_data_i;
        end
      end
      default: word = INVALID_PAT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_i;
      if (rd_i) rd_data_o <= word;
    end
  end

  a_r10_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rd_valid_o);
  a_r10_novalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rd_valid_o);
  a_r2_prog_poll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && state_i == ST_PROG) |=> rd_data_o[POLL_BIT] == !$past(pdata_b7_i));
  a_r3_erase_poll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && state_i == ST_ERASE) |=> !rd_data_o[POLL_BIT]);
  a_r6_susp_sector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && state_i == ST_SUSP && in_susp_i) |=>
      (rd_data_o[POLL_BIT] && rd_data_o[TOGA_BIT]));
  a_r7_other_sector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && state_i == ST_SUSP && !in_susp_i) |=> rd_data_o == $past(array_data_i));
endmodule

// File: rtl/flash_stat_gen.sv
module flash_stat_gen
  import flash_stat_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned LEN_W       = 16,
  parameter int unsigned SETTLE_CYC  = 50,
  parameter logic [DATA_W-1:0] INVALID_PAT = 16'hA5A5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              op_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DATA_W-1:0] prog_data_i,
  input  logic              suspend_i,
  input  logic              in_susp_sector_i,
  input  logic [DATA_W-1:0] array_data_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              ready_o
);
  localparam int unsigned SETTLE_W = (SETTLE_CYC < 1) ? 1 : $clog2(SETTLE_CYC + 1);
  localparam logic [SETTLE_W-1:0] SETTLE_LEN = SETTLE_W'(SETTLE_CYC);
  localparam int unsigned N_TOG = 2;

  fst_state_e st;
  logic acc_prog, acc_erase, finish, accept;
  logic prog_done, erase_done, settle_act;
  logic pdata_b7, last_b7;
  logic prog_run, erase_run, any_busy;
  logic prog_act_unused, erase_act_unused, settle_done_unused;
  logic [N_TOG-1:0] tog_en, tog_q;

  assign accept    = acc_prog || acc_erase;
  assign prog_run  = (st == ST_PROG) || (st == ST_SPROG);
  assign erase_run = (st == ST_ERASE);
  assign any_busy  = prog_run || erase_run;
  assign ready_o   = !any_busy;

  fst_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .op_i         (op_i),
    .suspend_i    (suspend_i),
    .data_b7_i    (prog_data_i[POLL_BIT]),
    .prog_done_i  (prog_done),
    .erase_done_i (erase_done),
    .state_o      (st),
    .acc_prog_o   (acc_prog),
    .acc_erase_o  (acc_erase),
    .finish_o     (finish),
    .pdata_b7_o   (pdata_b7),
    .last_b7_o    (last_b7)
  );

  fst_timer #(.W(LEN_W), .ZERO_IS_ONE(1'b1)) u_prog_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (1'b0),
    .load_i   (acc_prog),
    .len_i    (len_i),
    .run_i    (prog_run),
    .done_o   (prog_done),
    .active_o (prog_act_unused)
  );

  fst_timer #(.W(LEN_W), .ZERO_IS_ONE(1'b1)) u_erase_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (1'b0),
    .load_i   (acc_erase),
    .len_i    (len_i),
    .run_i    (erase_run),
    .done_o   (erase_done),
    .active_o (erase_act_unused)
  );

  fst_timer #(.W(SETTLE_W), .ZERO_IS_ONE(1'b0)) u_settle_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (accept),
    .load_i   (finish),
    .len_i    (SETTLE_LEN),
    .run_i    (1'b1),
    .done_o   (settle_done_unused),
    .active_o (settle_act)
  );

  // toggle 0 -> bit 6, toggle 1 -> bit 2
  assign tog_en[0] = rd_i && any_busy;
  assign tog_en[1] = rd_i && ((st == ST_ERASE) || (st == ST_SUSP && in_susp_sector_i));

  for (genvar g = 0; g < N_TOG; g++) begin : g_tog
    fst_toggle u_tog (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (accept),
      .en_i   (tog_en[g]),
      .q_o    (tog_q[g])
    );
  end

  fst_readout #(.DATA_W(DATA_W), .INVALID_PAT(INVALID_PAT)) u_readout (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .state_i      (st),
    .rd_i         (rd_i),
    .in_susp_i    (in_susp_sector_i),
    .array_data_i (array_data_i),
    .pdata_b7_i   (pdata_b7),
    .last_b7_i    (last_b7),
    .settle_i     (settle_act),
    .tog_a_i      (tog_q[0]),
    .tog_b_i      (tog_q[1]),
    .rd_data_o    (rd_data_o),
    .rd_valid_o   (rd_valid_o)
  );

  a_r1_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE && start_i) |=> !ready_o);
  a_r1_ready_in_susp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_SUSP && suspend_i && !start_i) |=> ready_o);
  a_r11_no_erase_in_susp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_SUSP && start_i && op_i && suspend_i) |=> st == ST_SUSP);
endmodule

// File: tb/test_flash_stat_gen.sv
module test_flash_stat_gen;
  localparam int unsigned SETTLE = 8;
  localparam logic [15:0] INV = 16'hA5A5;
  localparam logic [15:0] STAT_M = 16'h00C4;
  // {op[18], data[17:2], busy bit7[1], bit2 toggles[0]}
  localparam logic [18:0] VEC [4] = '{
    {1'b0, 16'h0080, 1'b0, 1'b0},
    {1'b0, 16'hFF7F, 1'b1, 1'b0},
    {1'b0, 16'hFFFF, 1'b0, 1'b0},
    {1'b1, 16'h0000, 1'b0, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, op = 1'b0, susp = 1'b0, in_ss = 1'b0, rd = 1'b0;
  logic [15:0] len = '0, pdata = '0, arr = '0;
  logic [15:0] rdata;
  logic rvalid, ready;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flash_stat_gen #(.SETTLE_CYC(SETTLE), .INVALID_PAT(INV)) i_flash_stat_gen (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .len_i(len),
    .prog_data_i(pdata), .suspend_i(susp), .in_susp_sector_i(in_ss),
    .array_data_i(arr), .rd_i(rd), .rd_data_o(rdata), .rd_valid_o(rvalid),
    .ready_o(ready)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_rd(output logic [15:0] d);
    rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
    chk("R10 valid", {15'd0, rvalid}, 16'd1);
  endtask

  task automatic do_start(input logic o, input logic [15:0] l, input logic [15:0] d);
    op = o; len = l; pdata = d; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_ready();
    for (int k = 0; k < 2000 && !ready; k++) @(negedge clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic tb7;
    arr = 16'h1357;
    repeat (3) @(negedge clk);
    chk("R12 ready at reset", {15'd0, ready}, 16'd1);
    chk("R12 valid at reset", {15'd0, rvalid}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    do_rd(d);
    chk("R12 idle read", d, 16'h1357);

    // table: polling / toggles / settle per pattern
    for (int v = 0; v < 4; v++) begin
      arr = 16'h3C00 + 16'(v);
      do_start(VEC[v][18], 16'd40, VEC[v][17:2]);
      tb7 = VEC[v][18] ? 1'b1 : VEC[v][9];
      for (int i = 0; i < 4; i++) begin
        chk("R1 busy", {15'd0, ready}, 16'd0);
        do_rd(d);
        chk(VEC[v][18] ? "R3 busy bit7" : "R2 busy bit7", {15'd0, d[7]}, {15'd0, VEC[v][1]});
        chk("R4 bit6", {15'd0, d[6]}, 16'(i % 2));
        chk("R5 bit2", {15'd0, d[2]}, VEC[v][0] ? 16'(i % 2) : 16'd0);
      end
      wait_ready();
      chk("R1 ready after done", {15'd0, ready}, 16'd1);
      do_rd(d);
      chk("R9 settle word", d, (INV & ~STAT_M) | (INV & 16'h0004) | {8'd0, tb7, 7'd0});
      chk(VEC[v][18] ? "R3 true bit7" : "R2 true bit7", {15'd0, d[7]}, {15'd0, tb7});
      repeat (SETTLE + 2) @(negedge clk);
      do_rd(d);
      chk("R9 array after settle", d, 16'h3C00 + 16'(v));
    end

    // start ignored while busy
    arr = 16'h2468;
    do_start(1'b1, 16'd30, 16'h0000);
    do_start(1'b0, 16'd1, 16'h0000);
    do_rd(d);
    chk("R11 erase keeps bit7", {15'd0, d[7]}, 16'd0);
    chk("R11 still busy", {15'd0, ready}, 16'd0);
    wait_ready();
    repeat (SETTLE + 2) @(negedge clk);

    // suspend scenario
    do_start(1'b1, 16'd60, 16'h0000);
    do_rd(d);
    do_rd(d);
    chk("R4 erase 2nd bit6", {15'd0, d[6]}, 16'd1);
    susp = 1'b1;
    @(negedge clk);
    chk("R1 ready in suspend", {15'd0, ready}, 16'd1);
    in_ss = 1'b1;
    do_rd(d);
    chk("R6 susp bit7", {15'd0, d[7]}, 16'd1);
    chk("R6 susp bit6", {15'd0, d[6]}, 16'd1);
    chk("R5 susp bit2 a", {15'd0, d[2]}, 16'd0);
    do_rd(d);
    chk("R5 susp bit2 b", {15'd0, d[2]}, 16'd1);
    in_ss = 1'b0;
    do_rd(d);
    chk("R7 other sector data", d, 16'h2468);
    in_ss = 1'b1;
    do_rd(d);
    chk("R7 toggle not advanced", {15'd0, d[2]}, 16'd0);
    do_start(1'b1, 16'd5, 16'h0000);
    chk("R11 erase start in suspend", {15'd0, ready}, 16'd1);
    do_rd(d);
    chk("R11 still suspended", {14'd0, d[7:6]}, 16'd3);
    // nested program outlasting remaining erase time
    in_ss = 1'b0;
    do_start(1'b0, 16'd80, 16'h0000);
    chk("R1 busy nested prog", {15'd0, ready}, 16'd0);
    do_rd(d);
    chk("R8 nested bit7", {15'd0, d[7]}, 16'd1);
    chk("R8 nested bit6 a", {15'd0, d[6]}, 16'd0);
    do_rd(d);
    chk("R8 nested bit6 b", {15'd0, d[6]}, 16'd1);
    wait_ready();
    chk("R8 back to suspend", {15'd0, ready}, 16'd1);
    in_ss = 1'b1;
    do_rd(d);
    chk("R8 susp after prog", {13'd0, d[7:6], d[2]}, 16'd6);
    susp = 1'b0;
    in_ss = 1'b0;
    @(negedge clk);
    chk("R8 erase resumed busy", {15'd0, ready}, 16'd0);
    do_rd(d);
    chk("R8 resumed bit7", {15'd0, d[7]}, 16'd0);
    chk("R8 resumed bit6", {15'd0, d[6]}, 16'd0);
    chk("R5 resumed bit2", {15'd0, d[2]}, 16'd1);
    wait_ready();
    do_rd(d);
    chk("R9 settle after erase", d, 16'hA5E5);
    repeat (SETTLE + 2) @(negedge clk);
    do_rd(d);
    chk("R9 array final", d, 16'h2468);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule